// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block turns a stream of parallel audio words into a time-division-multiplexed serial frame. It has two serial outputs: a frame-sync line (`ws_o`) and a serial data line (`sd_o`). It does not make its own bit clock. A one-cycle `bclk_en` tick from the surrounding clock generator marks each bit period. Each tick that is not stalled emits one bit, and the outputs change in the system clock cycle that follows that tick.

The frame is a run of slots. Static configuration sets:
- how many slots make up a frame and how many bit periods each slot lasts;
- how many data bits of a word are significant;
- which slots carry audio;
- the length and level of the frame-sync pulse;
- the bit order;
- whether data trails the frame-sync edge by one bit period;
- whether the input stream also carries placeholder words for muted slots.

Words enter on a valid/ready stream. The block requests a word only on a tick that starts a slot that takes one. If that word is missing and stop-on-empty is set, the block freezes and raises `bck_hold_o` so that the clock generator stops toggling the bit clock. If stop-on-empty is clear, the block keeps running and sends zeros for that slot.

Top module: `tdm_frame_ser`

## Requirements
- R1: A frame has `slot_last`+1 slots. Each slot lasts `bit_last`+1 emitted bits. Frames follow one another with no gap.
- R2: `s_ready` is high only during a `bclk_en` tick at bit 0 of a slot that takes a word. Exactly one word is accepted for each such slot while the stream keeps up.
- R3: A slot whose `chan_en` bit (bit index = slot number, slot 0 first in the frame) is 0 sends all zeros. With `skip_dis`=1 such a slot still consumes one stream word and discards it. With `skip_dis`=0 it consumes none.
- R4: `data_msb` holds the significant width minus one: 7, 15, 23 and 31 select 8, 16, 24 and 32 bits, taken from the low bits of `s_data`. The significant bits open the slot. Slot bits past them are zero. A slot shorter than the width truncates the word.
- R5: With `lsb_first`=0, bit `data_msb` is sent first and bit 0 last. With `lsb_first`=1, bit 0 is sent first.
- R6: `ws_o` equals `ws_pol` for the first `ws_last`+1 bits of every frame and equals the inverse of `ws_pol` for the rest of the frame.
- R7: With `one_bit_dly`=1, `sd_o` carries the bit that was due one bit period earlier, across slot and frame borders, and the first bit after reset is 0. With `one_bit_dly`=0, `sd_o` carries the bit that is due now.
- R8: With `stop_on_empty`=1, a word-taking slot start that finds `s_valid` low does not advance. In that case `ws_o` and `sd_o` hold and `bck_hold_o` is set. When the word arrives, the stream continues with nothing lost.
- R9: With `stop_on_empty`=0, a missing word makes the slot send zeros. No word is consumed, the frame keeps running and `bck_hold_o` stays 0.
- R10: After reset, `ws_o`, `sd_o` and `bck_hold_o` are 0.
- R11: `ws_o` and `sd_o` change only in the cycle after a `bclk_en` tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle tick per bit period |
| slot_last | input | 4 | Slots per frame minus one |
| bit_last | input | 5 | Bit periods per slot minus one |
| data_msb | input | 5 | Significant word width minus one |
| chan_en | input | 16 | Per-slot enable, bit n for slot n |
| ws_last | input | 9 | Frame-sync pulse length minus one |
| ws_pol | input | 1 | Frame-sync pulse level |
| lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| one_bit_dly | input | 1 | Delay data by one bit period |
| skip_dis | input | 1 | Stream also carries words for muted slots |
| stop_on_empty | input | 1 | Halt when a needed word is missing |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted this cycle when valid |
| s_data | input | 32 | Stream word, right-justified |
| ws_o | output | 1 | Frame-sync line |
| sd_o | output | 1 | Serial data line |
| bck_hold_o | output | 1 | Bit clock should be stopped |

## Verification
The assertions assume that every configuration input is constant between resets. The bench changes configuration only while reset is held. They also assume that `bclk_en` is a single-cycle pulse, so one tick moves the frame by at most one bit. The bench keeps its ticks on alternate cycles. Only `s_valid` is dropped at arbitrary points, and the stop and starvation behaviour is checked against that.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    localparam int MAX_SLOTS = 16;
    localparam int WORD_W    = 32;
    localparam int WSLEN_W   = 9;

    // one emitted bit period on the two serial lines
    typedef struct packed {
        logic ws;
        logic sd;
    } ser_bits_t;

    // frame-sync level at frame position pos
    function automatic logic ws_level(input int unsigned pos,
                                      input int unsigned pulse_last,
                                      input logic        pol);
        return (pos <= pulse_last) ? pol : ~pol;
    endfunction

endpackage

// File: rtl/tdm_frame_pos.sv
module tdm_frame_pos #(
    parameter int SLOT_IW = 4,
    parameter int BIT_IW  = 5,
    localparam int POS_W  = SLOT_IW + BIT_IW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [SLOT_IW-1:0] slot_last,
    input  logic [BIT_IW-1:0]  bit_last,
    output logic [SLOT_IW-1:0] slot,
    output logic [BIT_IW-1:0]  bitn,
    output logic [POS_W-1:0]   pos
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            bitn <= '0;
            pos  <= '0;
        end else if (adv) begin
            if (bitn == bit_last) begin
                bitn <= '0;
                if (slot == slot_last) begin
                    slot <= '0;
                    pos  <= '0;
                end else begin
                    slot <= slot + 1'b1;
                    pos  <= pos + 1'b1;
                end
            end else begin
                bitn <= bitn + 1'b1;
                pos  <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_bit_select.sv
module tdm_bit_select #(
    parameter int WORD_W = 32,
    localparam int BIT_IW = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BIT_IW-1:0] bitn,
    input  logic [BIT_IW-1:0] msb,
    input  logic              lsb_first,
    output logic              bit_out
);
    logic [BIT_IW-1:0] idx;

    always_comb begin
        idx = lsb_first ? bitn : (msb - bitn);
        bit_out = (bitn > msb) ? 1'b0 : word[idx];
    end
endmodule

// File: rtl/tdm_ser_out.sv
module tdm_ser_out
    import tdm_ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      adv,
    input  ser_bits_t nxt,
    input  logic      one_bit_dly,
    output ser_bits_t line,
    output logic      hold
);
    logic dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line  <= '0;
            dly_q <= 1'b0;
            hold  <= 1'b0;
        end else begin
            if (tick) hold <= ~adv;
            if (adv) begin
                line.ws <= nxt.ws;
                line.sd <= one_bit_dly ? dly_q : nxt.sd;
                dly_q   <= nxt.sd;
            end
        end
    end
endmodule

// File: rtl/tdm_frame_ser.sv
module tdm_frame_ser
    import tdm_ser_pkg::*;
#(
    parameter int N_SLOTS = MAX_SLOTS,
    parameter int DATA_W  = WORD_W,
    parameter int WSW     = WSLEN_W,
    localparam int SLOT_IW = $clog2(N_SLOTS),
    localparam int BIT_IW  = $clog2(DATA_W),
    localparam int POS_W   = SLOT_IW + BIT_IW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bclk_en,
    input  logic [SLOT_IW-1:0] slot_last,
    input  logic [BIT_IW-1:0]  bit_last,
    input  logic [BIT_IW-1:0]  data_msb,
    input  logic [N_SLOTS-1:0] chan_en,
    input  logic [WSW-1:0]     ws_last,
    input  logic               ws_pol,
    input  logic               lsb_first,
    input  logic               one_bit_dly,
    input  logic               skip_dis,
    input  logic               stop_on_empty,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [DATA_W-1:0]  s_data,
    output logic               ws_o,
    output logic               sd_o,
    output logic               bck_hold_o
);
    logic [SLOT_IW-1:0] cur_slot;
    logic [BIT_IW-1:0]  cur_bit;
    logic [POS_W-1:0]   cur_pos;
    logic [N_SLOTS-1:0] take_vec;
    logic               slot_on, need_word, stall, adv, got_word;
    logic [DATA_W-1:0]  fresh_word, word_q, cur_word;
    logic               raw_bit;
    ser_bits_t          nxt_bits, line_bits;

    // per-slot decision: does this slot pull a word from the stream
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_take
        assign take_vec[g] = chan_en[g] | skip_dis;
    end

    tdm_frame_pos #(.SLOT_IW(SLOT_IW), .BIT_IW(BIT_IW)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .slot_last (slot_last),
        .bit_last  (bit_last),
        .slot      (cur_slot),
        .bitn      (cur_bit),
        .pos       (cur_pos)
    );

    always_comb begin
        slot_on    = chan_en[cur_slot];
        need_word  = (cur_bit == '0) && take_vec[cur_slot];
        s_ready    = bclk_en && need_word;
        got_word   = s_ready && s_valid;
        stall      = s_ready && !s_valid && stop_on_empty;
        adv        = bclk_en && !stall;
        fresh_word = (slot_on && got_word) ? s_data : '0;
        cur_word   = (cur_bit == '0) ? fresh_word : word_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                          word_q <= '0;
        else if (adv && cur_bit == '0)    word_q <= fresh_word;
    end

    tdm_bit_select #(.WORD_W(DATA_W)) u_sel (
        .word      (cur_word),
        .bitn      (cur_bit),
        .msb       (data_msb),
        .lsb_first (lsb_first),
        .bit_out   (raw_bit)
    );

    always_comb begin
        nxt_bits.ws = ws_level(int'(cur_pos), int'(ws_last), ws_pol);
        nxt_bits.sd = raw_bit;
    end

    tdm_ser_out u_out (
        .clk         (clk),
        .rst         (rst),
        .tick        (bclk_en),
        .adv         (adv),
        .nxt         (nxt_bits),
        .one_bit_dly (one_bit_dly),
        .line        (line_bits),
        .hold        (bck_hold_o)
    );

    assign ws_o = line_bits.ws;
    assign sd_o = line_bits.sd;
endmodule

// File: rtl/tdm_frame_ser_chk.sv
module tdm_frame_ser_chk #(
    parameter int N_SLOTS = 16,
    parameter int SLOT_IW = 4,
    parameter int POS_W   = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               bclk_en,
    input logic               s_valid,
    input logic               s_ready,
    input logic               stop_on_empty,
    input logic               skip_dis,
    input logic [N_SLOTS-1:0] chan_en,
    input logic               ws_pol,
    input logic               ws_o,
    input logic               sd_o,
    input logic               bck_hold_o,
    input logic [SLOT_IW-1:0] cur_slot,
    input logic [POS_W-1:0]   cur_pos,
    input logic               adv
);
    p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> bclk_en);

    p_muted_no_take_r3: assert property (@(posedge clk) disable iff (rst)
        (!skip_dis && !chan_en[cur_slot]) |-> !s_ready);

    p_ws_frame_start_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && cur_pos == '0) |=> (ws_o == $past(ws_pol)));

    p_stall_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid && stop_on_empty) |=> ($stable(ws_o) && $stable(sd_o) && bck_hold_o));

    p_no_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (bclk_en && !stop_on_empty) |=> !bck_hold_o);

    p_quiet_between_ticks_r11: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> ($stable(ws_o) && $stable(sd_o)));
endmodule

bind tdm_frame_ser tdm_frame_ser_chk #(
    .N_SLOTS (N_SLOTS),
    .SLOT_IW (SLOT_IW),
    .POS_W   (POS_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bclk_en       (bclk_en),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .stop_on_empty (stop_on_empty),
    .skip_dis      (skip_dis),
    .chan_en       (chan_en),
    .ws_pol        (ws_pol),
    .ws_o          (ws_o),
    .sd_o          (sd_o),
    .bck_hold_o    (bck_hold_o),
    .cur_slot      (cur_slot),
    .cur_pos       (cur_pos),
    .adv           (adv)
);

// File: tb/tdm_frame_ser_tb_top.sv
module tdm_frame_ser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0;
    logic [3:0]  slot_last = '0;
    logic [4:0]  bit_last = '0;
    logic [4:0]  data_msb = '0;
    logic [15:0] chan_en = '1;
    logic [8:0]  ws_last = '0;
    logic        ws_pol = 1'b0, lsb_first = 1'b0, one_bit_dly = 1'b0;
    logic        skip_dis = 1'b0, stop_on_empty = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        ws_o, sd_o, bck_hold_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit exp_raw [2048];
    bit exp_ws  [2048];
    int exp_hs;

    always #10 clk = ~clk;

    tdm_frame_ser dut_i (
        .clk(clk), .rst(rst), .bclk_en(bclk_en),
        .slot_last(slot_last), .bit_last(bit_last), .data_msb(data_msb),
        .chan_en(chan_en), .ws_last(ws_last), .ws_pol(ws_pol),
        .lsb_first(lsb_first), .one_bit_dly(one_bit_dly), .skip_dis(skip_dis),
        .stop_on_empty(stop_on_empty), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .ws_o(ws_o), .sd_o(sd_o), .bck_hold_o(bck_hold_o)
    );

    function automatic logic [31:0] word_of(int k);
        return (k * 32'h9E3779B1) + 32'h1234_5677;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int ls, input int cb, input int bm, input int wsw,
                            input logic [15:0] en, input bit lsb, input bit dly,
                            input bit pol, input bit skip, input bit stop, input bit starve);
        int k, t, nt, kk, tk, hs_cnt, stall_left, idx;
        bit pend, stallpend, phase, pws, psd, expsd;
        logic [31:0] w, d;
        // configuration only changes under reset
        @(negedge clk);
        rst = 1'b1; bclk_en = 1'b0; s_valid = 1'b0;
        slot_last = 4'(ls); bit_last = 5'(cb); data_msb = 5'(bm); ws_last = 9'(wsw);
        chan_en = en; lsb_first = lsb; one_bit_dly = dly; ws_pol = pol;
        skip_dis = skip; stop_on_empty = stop;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // reference stream computed from the requirements
        k = 0; t = 0; exp_hs = 0;
        for (int f = 0; f < 3; f++) begin
            for (int s = 0; s <= ls; s++) begin
                d = '0;
                if ((en[s] || skip) && !starve) begin
                    w = word_of(k); k++; exp_hs++;
                    if (en[s]) d = w;
                end
                for (int b = 0; b <= cb; b++) begin
                    if (b > bm) exp_raw[t] = 1'b0;
                    else exp_raw[t] = lsb ? d[b] : d[bm - b];
                    exp_ws[t] = ((s * (cb + 1) + b) <= wsw) ? pol : ~pol;
                    t++;
                end
            end
        end
        nt = t;
        kk = 0; tk = 0; hs_cnt = 0; idx = 0;
        stall_left = (stop && !starve) ? 3 : 0;
        pend = 0; stallpend = 0; phase = 0; pws = 0; psd = 0;
        while (tk < nt || pend || stallpend) begin
            @(negedge clk);
            if (pend) begin
                expsd = dly ? ((idx == 0) ? 1'b0 : exp_raw[idx - 1]) : exp_raw[idx];
                chk(sd_o == expsd, "R3 R4 R5 R7 sd_o", int'(sd_o), int'(expsd));
                chk(ws_o == exp_ws[idx], "R1 R6 ws_o", int'(ws_o), int'(exp_ws[idx]));
                chk(bck_hold_o == 1'b0, "R8 R9 hold after advance", int'(bck_hold_o), 0);
                pws = ws_o; psd = sd_o; pend = 0;
            end
            if (stallpend) begin
                chk(bck_hold_o == 1'b1, "R8 hold on empty", int'(bck_hold_o), 1);
                chk(ws_o == pws && sd_o == psd, "R8 lines frozen",
                    int'({ws_o, sd_o}), int'({pws, psd}));
                stallpend = 0;
            end
            if (tk >= nt) begin
                bclk_en = 1'b0; s_valid = 1'b0;
            end else if (phase) begin
                bclk_en = 1'b1;
                s_valid = starve ? 1'b0 : !(kk == 2 && stall_left > 0);
                s_data  = word_of(kk);
                #1;
                if (s_ready && s_valid) begin kk++; hs_cnt++; end
                if (s_ready && !s_valid && stop) begin
                    stallpend = 1; stall_left--;
                end else begin
                    pend = 1; idx = tk; tk++;
                end
            end else begin
                bclk_en = 1'b0; s_valid = 1'b1;
                #1;
                chk(s_ready == 1'b0, "R2 R11 ready off tick", int'(s_ready), 0);
            end
            phase = !phase;
        end
        bclk_en = 1'b0; s_valid = 1'b0;
        chk(hs_cnt == exp_hs, "R2 R3 words taken", hs_cnt, exp_hs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state, still in reset
        chk(ws_o == 1'b0, "R10 ws_o reset", int'(ws_o), 0);
        chk(sd_o == 1'b0, "R10 sd_o reset", int'(sd_o), 0);
        chk(bck_hold_o == 1'b0, "R10 hold reset", int'(bck_hold_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(s_ready == 1'b0, "R2 no ready without tick", int'(s_ready), 0);
        // sweep bit order, delay, polarity, skip over three slot shapes
        for (int shape = 0; shape < 3; shape++) begin
            for (int c = 0; c < 16; c++) begin
                case (shape)
                    0: run_case(3, 9, 7, 0, 16'b1011, c[0], c[1], c[2], c[3], 1'b1, 1'b0);
                    1: run_case(3, 5, 7, 3, 16'b0110, c[0], c[1], c[2], c[3], 1'b1, 1'b0);
                    default: run_case(2, 15, 15, 15, 16'b101, c[0], c[1], c[2], c[3], 1'b1, 1'b0);
                endcase
            end
        end
        // R1 full frame, 32-bit words, mixed mask
        run_case(15, 31, 31, 0, 16'hA5C3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R4 24-bit data in 32-bit slots, skip mode
        run_case(1, 31, 23, 31, 16'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R9 starved stream without stop: zeros, no hold, no words
        run_case(3, 7, 7, 1, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule